// File: doc/BRIEF.md
# Shift-Add Quadratic Sequence Generator

This block emits the integer sequence x*(x+1) for x = 0, 1, 2, and so on. Each term is computed from scratch by a shift-and-add multiply on a 26-bit datapath. Each loop pass retires two multiplier bits. The accumulator is seeded with x, so that the product x*x plus the seed gives the term.

The 26-bit term is folded to 15 bits by XOR-ing its upper bits onto its lower bits. It is then offered to a consumer over a four-phase return-to-zero request/acknowledge port. The consumer drives the acknowledge line with no timing relation to the clock, so the block resynchronises it internally.

The next term is computed while the current handshake is still in progress. That term is moved to the output register only once both lines are back at zero. A consumer may also tie acknowledge straight to request to draw a continuous stream.

Top module: `quad_seq_gen`

## Requirements
- R1: While reset is asserted and directly after it, req_o is 0 and result_o is 0. The first term offered after reset is 0.
- R2: The k-th term offered after reset (k counted from 0) is fold(k*(k+1)), with consecutive k and none skipped or repeated.
- R3: All arithmetic wraps modulo 2^26. For example, the term for k = 8192 is 8192*8193 mod 2^26 = 8192, and result_o shows 8192.
- R4: fold(v) = v[14:0] XOR (v >> 15)[14:0]. For example, the term for k = 300 (90300) is shown as 24766.
- R5: The pair (req_o, ack_i) moves only through 00 -> 10 -> 11 -> 01 -> 00. req_o rises only while the synchronised acknowledge is low.
- R6: result_o holds the new value for at least one cycle before req_o rises, and holds it unchanged for as long as req_o is high.
- R7: req_o falls only after ack_i has been seen high. A new request is raised only after ack_i has been seen low again.
- R8: With ack_i tied to req_o, the block delivers an unbroken stream of correct terms without deadlock.
- R9: ack_i passes through a two-flop synchronizer. req_o falls on the third rising clock edge after ack_i rises.
- R10: Terms are computed during the handshake. When the next term is ready, req_o rises on the fifth rising clock edge after ack_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ack_i | input | 1 | Consumer acknowledge, asynchronous to clk_i |
| req_o | output | 1 | Request: result_o holds a valid term |
| result_o | output | 15 | Folded term |

## Verification
The multiplier loop finishing a term and the output port returning to idle can fall in the same cycle. So can a take from the port and an engine that is still iterating. Tying ack_i to req_o drives the port back to idle as fast as the synchronizer allows, so the port often waits on the engine; this continues for over 8000 terms, well past the 26-bit wrap. A consumer with slow random delays makes the term ready first. In both cases every offered value is compared with x*(x+1) computed modulo 2^26 and folded, and in the slow case the request latency after acknowledge falls is also timed.

// File: rtl/qsg_pkg.sv
package qsg_pkg;
  typedef enum logic [1:0] {ENG_LOAD, ENG_ITER, ENG_DONE} eng_state_e;
  typedef enum logic [1:0] {HS_IDLE, HS_ARM, HS_WAIT_HI, HS_WAIT_LO} hs_state_e;
endpackage

// File: rtl/qsg_sync.sv
module qsg_sync #(
  parameter int STAGES = 2  // >= 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] s_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) s_q <= '0;
    else         s_q <= {s_q[STAGES-2:0], d_i};
  end

  assign q_o = s_q[STAGES-1];
endmodule

// File: rtl/qsg_engine.sv
module qsg_engine
  import qsg_pkg::*;
#(
  parameter int DATA_W = 26,
  parameter int STEPS  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] term_o
);
  eng_state_e        st_q;
  logic [DATA_W-1:0] x_q, a_q, b_q, c_q;

  // unrolled shift-add steps
  logic [STEPS:0][DATA_W-1:0] a_s, b_s, c_s;
  assign a_s[0] = a_q;
  assign b_s[0] = b_q;
  assign c_s[0] = c_q;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    assign c_s[i+1] = c_s[i] + (b_s[i][0] ? a_s[i] : '0);
    assign a_s[i+1] = a_s[i] << 1;
    assign b_s[i+1] = b_s[i] >> 1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ENG_LOAD;
      x_q  <= '0;
      a_q  <= '0;
      b_q  <= '0;
      c_q  <= '0;
    end else begin
      unique case (st_q)
        ENG_LOAD: begin
          a_q  <= x_q;
          b_q  <= x_q;
          c_q  <= x_q;
          x_q  <= x_q + DATA_W'(1);
          st_q <= ENG_ITER;
        end
        ENG_ITER: begin
          if (b_q == '0) begin
            st_q <= ENG_DONE;
          end else begin
            a_q <= a_s[STEPS];
            b_q <= b_s[STEPS];
            c_q <= c_s[STEPS];
          end
        end
        ENG_DONE: if (take_i) st_q <= ENG_LOAD;
        default:  st_q <= ENG_LOAD;
      endcase
    end
  end

  assign valid_o = (st_q == ENG_DONE);
  assign term_o  = c_q;

  // R2
  term_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> c_q == (x_q - DATA_W'(1)) * x_q);

  // R3
  pass_invariant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ENG_ITER && b_q != '0) |=> (c_q + a_q * b_q) == $past(c_q + a_q * b_q));
endmodule

// File: rtl/qsg_hs_port.sv
module qsg_hs_port
  import qsg_pkg::*;
#(
  parameter int DATA_W = 26,
  parameter int OUT_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ack_s_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] term_i,
  output logic              take_o,
  output logic              req_o,
  output logic [OUT_W-1:0]  result_o
);
  hs_state_e         st_q;
  logic              req_q;
  logic [OUT_W-1:0]  res_q;
  logic [DATA_W-1:0] hi_bits;
  logic [OUT_W-1:0]  folded;

  assign hi_bits = term_i >> OUT_W;
  assign folded  = term_i[OUT_W-1:0] ^ hi_bits[OUT_W-1:0];
  assign take_o  = (st_q == HS_IDLE) && valid_i && !ack_s_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= HS_IDLE;
      req_q <= 1'b0;
      res_q <= '0;
    end else begin
      unique case (st_q)
        HS_IDLE: if (take_o) begin
          res_q <= folded;
          st_q  <= HS_ARM;
        end
        HS_ARM: begin  // one cycle of data setup before req
          req_q <= 1'b1;
          st_q  <= HS_WAIT_HI;
        end
        HS_WAIT_HI: if (ack_s_i) begin
          req_q <= 1'b0;
          st_q  <= HS_WAIT_LO;
        end
        HS_WAIT_LO: if (!ack_s_i) st_q <= HS_IDLE;
        default:    st_q <= HS_IDLE;
      endcase
    end
  end

  assign req_o    = req_q;
  assign result_o = res_q;

  // R5
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> !ack_s_i);

  // R7
  req_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(req_q) |-> $past(ack_s_i));

  // R6
  data_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(req_q) |-> $stable(res_q));

  // R6
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |=> $stable(res_q));
endmodule

// File: rtl/quad_seq_gen.sv
module quad_seq_gen #(
  parameter int DATA_W      = 26,
  parameter int OUT_W       = 15,
  parameter int STEPS       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ack_i,
  output logic             req_o,
  output logic [OUT_W-1:0] result_o
);
  logic              ack_s;
  logic              take;
  logic              valid;
  logic [DATA_W-1:0] term;

  qsg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_i),
    .q_o   (ack_s)
  );

  qsg_engine #(.DATA_W(DATA_W), .STEPS(STEPS)) u_engine (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (take),
    .valid_o(valid),
    .term_o (term)
  );

  qsg_hs_port #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_port (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ack_s_i (ack_s),
    .valid_i (valid),
    .term_i  (term),
    .take_o  (take),
    .req_o   (req_o),
    .result_o(result_o)
  );
endmodule

// File: tb/tb_quad_seq_gen.sv
`timescale 1ns/100ps
module tb_quad_seq_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ack_drv = 1'b0;
  logic        tie = 1'b0;
  logic        ack_w;
  logic        req_w;
  logic [14:0] res_w;

  int checks = 0;
  int errors = 0;
  int unsigned k = 0;
  logic        prev_req = 1'b0;
  logic        prev_ack = 1'b0;
  logic [14:0] prev_res = '0;

  always #2.5 clk = ~clk;  // 200 MHz

  assign ack_w = tie ? req_w : ack_drv;

  quad_seq_gen dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .ack_i   (ack_w),
    .req_o   (req_w),
    .result_o(res_w)
  );

  function automatic logic [14:0] exp_val(int unsigned n);
    logic [25:0] nn;
    logic [25:0] v;
    nn = 26'(n);
    v  = nn * (nn + 26'd1);
    return v[14:0] ^ {4'b0, v[25:15]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit legal_step(logic [1:0] p, logic [1:0] c);
    if (p == c) return 1'b1;
    case (p)
      2'b00: return c == 2'b10;
      2'b10: return c == 2'b11;
      2'b11: return c == 2'b01;
      default: return c == 2'b00;
    endcase
  endfunction

  // monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      k        = 0;
      prev_req = 1'b0;
      prev_ack = 1'b0;
      prev_res = res_w;
    end else begin
      if (!tie)  // R5 R7
        chk(legal_step({prev_req, prev_ack}, {req_w, ack_w}), "R5/R7 phase",
            int'({req_w, ack_w}), int'({prev_req, prev_ack}));
      if (req_w && !prev_req) begin
        chk(res_w == prev_res, "R6 setup", int'(res_w), int'(prev_res));
        chk(res_w == exp_val(k), "R2 value", int'(res_w), int'(exp_val(k)));
        if (k == 300)  chk(res_w == 15'd24766, "R4 fold", int'(res_w), 24766);
        if (k == 8192) chk(res_w == 15'd8192, "R3 wrap", int'(res_w), 8192);
        k++;
      end else if (req_w && prev_req) begin
        chk(res_w == prev_res, "R6 hold", int'(res_w), int'(prev_res));
      end
      prev_req = req_w;
      prev_ack = ack_w;
      prev_res = res_w;
    end
  end

  task automatic slow_terms(input int n);
    for (int t = 0; t < n; t++) begin
      int cnt;
      int guard;
      guard = 0;
      while (!req_w && guard < 100) begin
        @(negedge clk);
        guard++;
      end
      repeat (8 + $urandom_range(20)) @(negedge clk);
      #1 ack_drv = 1'b1;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (req_w && cnt < 20);
      chk(cnt == 3, "R9 req fall latency", cnt, 3);
      repeat (8 + $urandom_range(20)) @(negedge clk);
      #1 ack_drv = 1'b0;
      cnt = 0;
      do begin @(negedge clk); cnt++; end while (!req_w && cnt < 40);
      chk(cnt == 5, "R10 req rise latency", cnt, 5);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", k, 8300);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(req_w == 1'b0, "R1 req in reset", int'(req_w), 0);
    chk(res_w == 15'd0, "R1 result in reset", int'(res_w), 0);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(req_w == 1'b0, "R1 req after reset", int'(req_w), 0);

    slow_terms(40);
    chk(k >= 40, "R2 slow count", int'(k), 40);

    // continuous stream: R8
    @(negedge clk);
    while (!req_w) @(negedge clk);
    #1 tie = 1'b1;
    begin
      int cyc;
      cyc = 0;
      while (k < 8300 && cyc < 150000) begin
        @(negedge clk);
        cyc++;
      end
    end
    chk(k >= 8300, "R8 tied stream", int'(k), 8300);
    while (req_w) @(negedge clk);
    #1 begin ack_drv = 1'b0; tie = 1'b0; end

    slow_terms(10);

    // mid-run reset: R1
    @(negedge clk);
    #1 begin rst_n = 1'b0; ack_drv = 1'b0; end
    repeat (3) @(negedge clk);
    chk(req_w == 1'b0, "R1 req mid reset", int'(req_w), 0);
    chk(res_w == 15'd0, "R1 result mid reset", int'(res_w), 0);
    #1 rst_n = 1'b1;
    slow_terms(3);
    chk(k >= 3, "R1 restart count", int'(k), 3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule